// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a single Serial Wire Debug transaction. A command names the target port (debug port or access port), the direction, the two register address bits and, for writes, a 32-bit word. The engine generates the debug clock, drives or releases the bidirectional data line through an output enable, and sends the 8-bit request. It then hands the line to the target, reads the 3-bit acknowledge, and either moves 32 data bits plus an even-parity bit or abandons the data phase.

Each transaction ends with a one-cycle response that carries a status code and, for reads, the received word. If the target answers WAIT, the engine waits a short stretch with the line held low and then sends the same request again. It does this up to a fixed number of times before it reports WAIT. The debug clock speed comes from a divider input: one debug clock period is four divider ticks, and each tick lasts `clk_div` system cycles.

Top module: `swd_host_engine`

## Requirements
- R1: The request goes out first-bit-first as: 1 (start), port select (1 = access port), direction (1 = read), address bit 0, address bit 1, even parity of those four bits, 0 (stop), 1 (park). The start bit is on the line in the cycle after a command is accepted.
- R2: One debug clock period lasts exactly 4*D system cycles, where D = `clk_div`, and a `clk_div` of 0 counts as 1. The clock is low for the first half of each period. The host changes its driven value and enable only while the clock is low, and it samples `swdio_in` at the rising edge.
- R3: The host releases the line (`swdio_oe` = 0) during the turnaround period after the request, the three acknowledge periods, and the read data periods. For a write, it releases the line for one turnaround period after the acknowledge and then drives all 33 data-phase periods.
- R4: The first-received acknowledge bit is bit 0 of the acknowledge code. Code 001 is OK, 010 is WAIT, 100 is FAULT, and any other value is a protocol error. `rsp_status` encodes OK = 0, WAIT = 1, FAULT = 2, protocol error = 3 and parity error = 4.
- R5: A read data phase carries 32 bits, least significant first, followed by a parity bit. `rsp_rdata` returns the word. If the parity bit is not the even parity of the word, the status is 4 and the word is still returned. `rsp_rdata` is 0 for writes and for reads that got no data phase.
- R6: A write data phase drives `cmd_wdata` least significant bit first, followed by its even parity bit.
- R7: After a WAIT, the engine re-sends the identical request, up to RETRY_LIMIT times (default 5). If all RETRY_LIMIT+1 attempts are answered WAIT, the status is 1.
- R8: Between a WAIT and the retry, the engine inserts one turnaround period and then GAP_CYCLES periods (default 2) with the line driven low.
- R9: After a FAULT or a protocol-error acknowledge, the engine skips the data phase. It spends one turnaround period and then responds, so an attempt of this kind lasts 13 periods.
- R10: `rsp_valid` is a one-cycle pulse exactly 4*D*N system cycles after the accepting clock edge. N is 46 for a transaction that ends with OK, 13 for one that ends otherwise, plus 13+GAP_CYCLES for each retry. `cmd_ready` is high only when the engine is idle.
- R11: In reset and when idle, `swclk` is low, `swdio_oe` is 1, `swdio_out` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | System cycles per quarter debug clock period (0 counts as 1) |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle; command accepted when both are high |
| cmd_ap | input | 1 | 1 = access port, 0 = debug port |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register address bits (bit 0 = A2, bit 1 = A3) |
| cmd_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 3 | Completion code (see R4) |
| rsp_rdata | output | 32 | Read word |
| swclk | output | 1 | Debug clock |
| swdio_out | output | 1 | Driven data line value |
| swdio_oe | output | 1 | Data line output enable |
| swdio_in | input | 1 | Data line as seen at the pin |

## Verification
The response is due exactly 4*D*N system cycles after the accepting edge. The bench counts cycles from the negative edge that follows acceptance up to the negative edge where `rsp_valid` is seen, and compares the difference with that formula for every transaction. All line-level results are checked by a bench target model at debug clock edges, never at system clock edges. It checks request bits and write bits at each rising edge, drives acknowledge and read bits on each falling edge, and confirms the host's enable in every turnaround, acknowledge and data period. That model also checks each debug clock period against 4*D cycles and counts the driven-low gap periods before every retried request.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  typedef enum logic [2:0] {
    ST_OK     = 3'd0,
    ST_WAIT   = 3'd1,
    ST_FAULT  = 3'd2,
    ST_PROTO  = 3'd3,
    ST_PARITY = 3'd4
  } swd_status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_TRN_A, S_ACK, S_TRN_W,
    S_WDATA, S_RDATA, S_TRN_E, S_TRN_R, S_GAP
  } swd_seq_e;

  // Request byte, bit 0 leaves first.
  function automatic logic [7:0] swd_req_byte(input logic ap, input logic rd,
                                               input logic [1:0] adr);
    logic par;
    par = ap ^ rd ^ adr[0] ^ adr[1];
    return {1'b1, 1'b0, par, adr[1], adr[0], rd, ap, 1'b1};
  endfunction

  function automatic swd_status_e swd_ack_class(input logic [2:0] ack);
    case (ack)
      3'b001:  return ST_OK;
      3'b010:  return ST_WAIT;
      3'b100:  return ST_FAULT;
      default: return ST_PROTO;
    endcase
  endfunction

  function automatic logic even_par32(input logic [31:0] d);
    return ^d;
  endfunction

endpackage

// File: rtl/swd_tick_gen.sv
module swd_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic [1:0]       phase
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 2'd0;
    end else if (!run) begin
      cnt   <= '0;
      phase <= 2'd0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= phase + 2'd1;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/swd_bit_seq.sv
module swd_bit_seq
  import swd_host_pkg::*;
#(
  parameter int RETRY_LIMIT = 5,
  parameter int GAP_CYCLES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [1:0]  phase,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_ap,
  input  logic        cmd_read,
  input  logic [1:0]  cmd_addr,
  input  logic [31:0] cmd_wdata,
  input  logic        line_in,
  output logic        run,
  output logic        drive_en,
  output logic        drive_bit,
  output logic        rsp_valid,
  output logic [2:0]  rsp_status,
  output logic [31:0] rsp_rdata,
  output logic        ev_retry
);
  localparam int RTY_W   = $clog2(RETRY_LIMIT + 2);
  localparam bit HAS_GAP = (GAP_CYCLES > 0);

  swd_seq_e    st;
  swd_status_e pend;
  logic [5:0]  bitcnt;
  logic [7:0]  req;
  logic [31:0] wdat, rdat;
  logic        rnw, rpar;
  logic [2:0]  ack;
  logic [RTY_W-1:0] retries;
  logic        slot_end, ack_last, can_retry;

  assign slot_end  = tick && (phase == 2'd3);
  assign ack_last  = slot_end && (st == S_ACK) && (bitcnt == 6'd2);
  assign can_retry = (retries < RTY_W'(RETRY_LIMIT));
  assign ev_retry  = ack_last && (swd_ack_class(ack) == ST_WAIT) && can_retry;

  assign run       = (st != S_IDLE);
  assign cmd_ready = (st == S_IDLE);
  assign drive_en  = (st == S_IDLE) || (st == S_REQ) || (st == S_WDATA) || (st == S_GAP);

  always_comb begin
    case (st)
      S_REQ:   drive_bit = req[bitcnt[2:0]];
      S_WDATA: drive_bit = (bitcnt == 6'd32) ? even_par32(wdat) : wdat[bitcnt[4:0]];
      default: drive_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= ST_OK; bitcnt <= '0; req <= '0;
      wdat <= '0; rdat <= '0; rnw <= 1'b0; rpar <= 1'b0; ack <= '0;
      retries <= '0; rsp_valid <= 1'b0; rsp_status <= '0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (st == S_IDLE) begin
        if (cmd_valid) begin
          req     <= swd_req_byte(cmd_ap, cmd_read, cmd_addr);
          wdat    <= cmd_wdata;
          rnw     <= cmd_read;
          rdat    <= '0;
          retries <= '0;
          bitcnt  <= '0;
          st      <= S_REQ;
        end
      end else if (tick) begin
        // rising debug clock edge: sample the line
        if (phase == 2'd1) begin
          if (st == S_ACK) ack[bitcnt[1:0]] <= line_in;
          if (st == S_RDATA) begin
            if (bitcnt == 6'd32) rpar <= line_in;
            else                 rdat[bitcnt[4:0]] <= line_in;
          end
        end
        // falling debug clock edge: end of slot
        if (phase == 2'd3) begin
          case (st)
            S_REQ: begin
              if (bitcnt == 6'd7) begin st <= S_TRN_A; bitcnt <= '0; end
              else bitcnt <= bitcnt + 6'd1;
            end
            S_TRN_A: begin st <= S_ACK; bitcnt <= '0; end
            S_ACK: begin
              if (bitcnt == 6'd2) begin
                bitcnt <= '0;
                case (swd_ack_class(ack))
                  ST_OK:   st <= rnw ? S_RDATA : S_TRN_W;
                  ST_WAIT: begin
                    if (can_retry) begin
                      retries <= retries + RTY_W'(1);
                      st      <= S_TRN_R;
                    end else begin
                      pend <= ST_WAIT; st <= S_TRN_E;
                    end
                  end
                  ST_FAULT: begin pend <= ST_FAULT; st <= S_TRN_E; end
                  default:  begin pend <= ST_PROTO; st <= S_TRN_E; end
                endcase
              end else bitcnt <= bitcnt + 6'd1;
            end
            S_RDATA: begin
              if (bitcnt == 6'd32) begin
                pend <= (rpar == even_par32(rdat)) ? ST_OK : ST_PARITY;
                st   <= S_TRN_E;
              end else bitcnt <= bitcnt + 6'd1;
            end
            S_TRN_W: begin st <= S_WDATA; bitcnt <= '0; end
            S_WDATA: begin
              if (bitcnt == 6'd32) begin
                rsp_valid  <= 1'b1;
                rsp_status <= ST_OK;
                rsp_rdata  <= '0;
                st         <= S_IDLE;
              end else bitcnt <= bitcnt + 6'd1;
            end
            S_TRN_E: begin
              rsp_valid  <= 1'b1;
              rsp_status <= pend;
              rsp_rdata  <= rnw ? rdat : '0;
              st         <= S_IDLE;
            end
            S_TRN_R: begin
              bitcnt <= '0;
              st     <= HAS_GAP ? S_GAP : S_REQ;
            end
            S_GAP: begin
              if (int'(bitcnt) >= GAP_CYCLES - 1) begin st <= S_REQ; bitcnt <= '0; end
              else bitcnt <= bitcnt + 6'd1;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine #(
  parameter int DIV_W       = 8,
  parameter int RETRY_LIMIT = 5,
  parameter int GAP_CYCLES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_ap,
  input  logic             cmd_read,
  input  logic [1:0]       cmd_addr,
  input  logic [31:0]      cmd_wdata,
  output logic             rsp_valid,
  output logic [2:0]       rsp_status,
  output logic [31:0]      rsp_rdata,
  output logic             swclk,
  output logic             swdio_out,
  output logic             swdio_oe,
  input  logic             swdio_in
);
  logic       run, tick, ev_retry;
  logic [1:0] phase;

  swd_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div(clk_div),
    .tick(tick), .phase(phase)
  );

  swd_bit_seq #(.RETRY_LIMIT(RETRY_LIMIT), .GAP_CYCLES(GAP_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_ap(cmd_ap),
    .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .line_in(swdio_in), .run(run), .drive_en(swdio_oe), .drive_bit(swdio_out),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .ev_retry(ev_retry)
  );

  assign swclk = run && phase[1];
endmodule

// File: rtl/swd_host_engine_chk.sv
module swd_host_engine_chk #(
  parameter int RETRY_LIMIT = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       swclk,
  input logic       swdio_oe,
  input logic       swdio_out,
  input logic       rsp_valid,
  input logic [2:0] rsp_status,
  input logic       ev_retry
);
  logic [7:0] rty_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rty_cnt <= '0;
    else if (cmd_valid && cmd_ready) rty_cnt <= '0;
    else if (ev_retry)               rty_cnt <= rty_cnt + 8'd1;
  end

  // R11
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!swclk && swdio_oe && !swdio_out));

  // R2
  edge_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swclk |-> ($stable(swdio_out) && $stable(swdio_oe)));

  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (swdio_oe && swdio_out));

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R10
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry |-> (int'(rty_cnt) < RETRY_LIMIT));

  // R7
  wait_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 3'd1) |-> (int'(rty_cnt) == RETRY_LIMIT));

  // R4
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status <= 3'd4));
endmodule

bind swd_host_engine swd_host_engine_chk #(.RETRY_LIMIT(RETRY_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .swclk(swclk), .swdio_oe(swdio_oe), .swdio_out(swdio_out),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .ev_retry(ev_retry)
);

// File: tb/swd_host_engine_test.sv
`timescale 1ns/1ps
module swd_host_engine_test;
  localparam int RTY = 5;
  localparam int GAP = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd1;
  logic        cmd_valid = 1'b0, cmd_ap = 1'b0, cmd_read = 1'b0;
  logic [1:0]  cmd_addr = 2'd0;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_ready, rsp_valid, swclk, swdio_out, swdio_oe, swdio_in;
  logic [2:0]  rsp_status;
  logic [31:0] rsp_rdata;
  logic        t_en = 1'b0, t_bit = 1'b1;

  assign swdio_in = swdio_oe ? swdio_out : (t_en ? t_bit : 1'b1);

  swd_host_engine #(.DIV_W(8), .RETRY_LIMIT(RTY), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_ap(cmd_ap), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .swclk(swclk),
    .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in)
  );

  always #2.5 clk = ~clk;

  int cyc = 0, checks = 0, errors = 0;
  int last_rise = -1, per_bad = 0, eff_d = 1;
  int line_bad = 0, req_bad = 0, gap_bad = 0, attempts = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d (expected completion)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge swclk) begin
    if (last_rise >= 0 && (cyc - last_rise) != 4 * eff_d) per_bad++;
    last_rise = cyc;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_req(input bit ap, input bit rd, input logic [1:0] a);
    int ones;
    logic [7:0] r;
    ones = int'(ap) + int'(rd) + int'(a[0]) + int'(a[1]);
    r = 8'h81 | (8'(ap) << 1) | (8'(rd) << 2) | (8'(a) << 3);
    if (ones % 2 == 1) r = r | 8'h20;
    return r;
  endfunction

  task automatic target_serve(input logic [7:0] xr, input int nwait, input logic [2:0] fack,
                              input bit rd, input logic [31:0] rdat, input bit badp,
                              output logic [32:0] wcap);
    logic [7:0] rq;
    logic [2:0] ak;
    int gaps;
    bit again;
    wcap = '0;
    again = 1'b1;
    while (again) begin
      gaps = 0;
      forever begin
        @(posedge swclk);
        if (swdio_oe && swdio_out) break;
        if (swdio_oe) gaps++; else line_bad++;
      end
      if (gaps != ((attempts == 0) ? 0 : GAP)) gap_bad++;
      rq[0] = 1'b1;
      for (int i = 1; i < 8; i++) begin @(posedge swclk); rq[i] = swdio_out; end
      if (rq != xr) req_bad++;
      attempts++;
      ak = (attempts <= nwait) ? 3'b010 : fack;
      @(negedge swclk); @(posedge swclk); if (swdio_oe) line_bad++;
      for (int i = 0; i < 3; i++) begin
        @(negedge swclk); t_en = 1'b1; t_bit = ak[i];
        @(posedge swclk); if (swdio_oe) line_bad++;
      end
      again = 1'b0;
      if (ak == 3'b001 && rd) begin
        for (int i = 0; i < 33; i++) begin
          @(negedge swclk); t_bit = (i < 32) ? rdat[i] : ((^rdat) ^ badp);
          @(posedge swclk); if (swdio_oe) line_bad++;
        end
        @(negedge swclk); t_en = 1'b0;
        @(posedge swclk); if (swdio_oe) line_bad++;
      end else if (ak == 3'b001) begin
        @(negedge swclk); t_en = 1'b0;
        @(posedge swclk); if (swdio_oe) line_bad++;
        for (int i = 0; i < 33; i++) begin
          @(posedge swclk); if (!swdio_oe) line_bad++; wcap[i] = swdio_out;
        end
      end else begin
        @(negedge swclk); t_en = 1'b0;
        @(posedge swclk); if (swdio_oe) line_bad++;
        if (ak == 3'b010 && attempts <= RTY) again = 1'b1;
      end
    end
  endtask

  task automatic do_txn(input bit ap, input bit rd, input logic [1:0] a, input logic [31:0] wd,
                        input logic [31:0] rdat, input int nwait, input logic [2:0] fack,
                        input bit badp, input int dv);
    int t0, t1, nr, slots, exst;
    logic [32:0] wcap;
    logic [2:0]  st;
    logic [31:0] rdv;
    bit waitout;
    clk_div = 8'(dv);
    eff_d = (dv == 0) ? 1 : dv;
    last_rise = -1; per_bad = 0; line_bad = 0; req_bad = 0; gap_bad = 0; attempts = 0;
    waitout = (nwait > RTY);
    nr = waitout ? RTY : nwait;
    slots = nr * (13 + GAP) + ((!waitout && fack == 3'b001) ? 46 : 13);
    if (waitout) exst = 1;
    else if (fack == 3'b001) exst = (rd && badp) ? 4 : 0;
    else if (fack == 3'b100) exst = 2;
    else exst = 3;
    fork
      begin
        @(negedge clk);
        chk(cmd_ready, "R10 ready when idle", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_ap = ap; cmd_read = rd; cmd_addr = a; cmd_wdata = wd;
        @(negedge clk);
        t0 = cyc;
        cmd_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        t1 = cyc; st = rsp_status; rdv = rsp_rdata;
      end
      target_serve(exp_req(ap, rd, a), nwait, fack, rd, rdat, badp, wcap);
    join
    chk(st == 3'(exst), (exst == 4) ? "R5 parity status" : (exst == 1) ? "R7 wait status" : "R4 status",
        st, exst);
    chk(rdv == ((rd && !waitout && fack == 3'b001) ? rdat : 32'h0), "R5 read data", rdv,
        (rd && !waitout && fack == 3'b001) ? rdat : 32'h0);
    chk(t1 - t0 == 4 * eff_d * slots, (slots == 13) ? "R9 short attempt timing" : "R10 response timing",
        t1 - t0, 4 * eff_d * slots);
    chk(req_bad == 0, "R1 request bits", req_bad, 0);
    chk(attempts == nr + 1, "R7 attempt count", attempts, nr + 1);
    chk(line_bad == 0, "R3 line direction", line_bad, 0);
    chk(gap_bad == 0, "R8 retry gap", gap_bad, 0);
    chk(per_bad == 0, "R2 clock period", per_bad, 0);
    if (!rd && !waitout && fack == 3'b001)
      chk(wcap == {^wd, wd}, "R6 write bits", wcap, {^wd, wd});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!swclk, "R11 clock low", swclk, 0);
    chk(swdio_oe, "R11 oe high", swdio_oe, 1);
    chk(!swdio_out, "R11 line low", swdio_out, 0);
    chk(cmd_ready, "R11 ready", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid, "R11 no response", rsp_valid, 0);
    // sweep all request fields, both directions, two dividers
    for (int dv = 1; dv <= 2; dv++)
      for (int k = 0; k < 16; k++)
        do_txn(k[0], k[1], k[3:2], 32'h2468_ACE1 ^ (32'(k) * 32'h0109_0307) ^ 32'(dv << 28),
               32'hA5C3_0F96 ^ (32'(k) * 32'h0101_0101), 0, 3'b001, 1'b0, dv);
    // R4 / R9: every acknowledge code except WAIT, reads and writes
    for (int c = 0; c < 8; c++)
      if (c != 2)
        for (int r = 0; r < 2; r++)
          do_txn(1'b1, r[0], 2'(c), 32'hF0F0_1234 + 32'(c), 32'h8000_0001 << c, 0, 3'(c), 1'b0, 1);
    // R5: parity error on reads, divider 3 and 0
    do_txn(1'b0, 1'b1, 2'd1, 32'h0, 32'h0000_0000, 0, 3'b001, 1'b1, 3);
    do_txn(1'b1, 1'b1, 2'd2, 32'h0, 32'hFFFF_FFFE, 0, 3'b001, 1'b1, 0);
    do_txn(1'b1, 1'b0, 2'd3, 32'hFFFF_FFFF, 32'h0, 0, 3'b001, 1'b0, 0);
    // R7 / R8: WAIT runs up to and past the retry limit
    for (int n = 1; n <= RTY + 1; n++) begin
      do_txn(1'b1, 1'b1, 2'(n), 32'h0, 32'h1357_9BDF + 32'(n), n, 3'b001, 1'b0, 1);
      do_txn(1'b0, 1'b0, 2'(n + 1), 32'hCAFE_0000 + 32'(n), 32'h0, n, 3'b001, 1'b0, 2);
    end
    do_txn(1'b1, 1'b1, 2'd0, 32'h0, 32'h0, 2, 3'b100, 1'b0, 1);
    repeat (4) @(negedge clk);
    chk(cmd_ready && !swclk && swdio_oe && !swdio_out, "R11 idle after run",
        {cmd_ready, swclk, swdio_oe, swdio_out}, 4'b1010);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule